// File: doc/BRIEF.md
# Slot Identity Hotplug Detector

This peripheral watches four connector slots on a soft processor's on-chip peripheral bus. An attached board ties eight identification pins of its slot high or low. The pattern it ties is an identity code, and that code equals the number of the software driver that serves the board. An empty slot presents all zeros, so any nonzero code means that something is plugged in.

Each pin passes through a two-stage synchronizer. A per-slot filter then accepts a new code only after the synchronized code has held still for a programmable number of clock cycles. When a slot's accepted code changes, a sticky per-slot flag is set. This covers a board being plugged in, a board being pulled out, and one board being swapped for another. Software reads the codes and the flags over the bus and clears each flag by writing a 1 to it. A level interrupt is raised while any flag is set and the interrupt is enabled. The logic is kept small because it is present in every fabric configuration.

Top module: `hotplug_detect`

## Requirements
- R1: Reading byte offsets 0x00, 0x04, 0x08 and 0x0C returns the accepted code of slots 0 to 3 in bits 7:0, and bits 31:8 read as zero.
- R2: After reset, every accepted code, every change flag, the enable bit and the interrupt are zero. Reads of offsets 0x18 and above return zero.
- R3: A new pin pattern is accepted only after it has held still for DEBOUNCE cycles. A pattern that lasts a few cycles and then reverts leaves both the slot register and the change flags unchanged.
- R4: Bit i of the change register at offset 0x10 (bits 3:0, one per slot) is set when slot i's accepted code changes. This applies to an attach, a detach and a direct swap from one nonzero code to another.
- R5: Writing 1 to a change bit clears it, and writing 0 leaves it set. A bit that is set and cleared in the same cycle stays set. A change bit is cleared only by such a write.
- R6: Offset 0x14 bit 0 is a read/write interrupt enable. Its other bits read as zero.
- R7: The irq output is high one cycle after any change bit is set while the enable is 1. It is low one cycle after all change bits are clear or the enable is 0.
- R8: Writes to the slot register offsets have no effect on what those offsets read back.
- R9: A board that is already present when reset is released is reported as a change once its code is first accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| slot_pins | input | 4*8 | Raw identity pins; slot i uses bits 8i+7:8i |
| irq | output | 1 | Level interrupt |

## Verification
A wrong filter count shows up as a slot register that changes too early or too late. To expose it, the register is read both at half the filter window and just after the full window. A filter state that goes stale or a lost change pulse leaves a change flag missing a few cycles after acceptance. A flag that clears on its own, or a wrong set/clear priority, leaves the interrupt level wrong within two cycles of the enable or clear write. Because both are visible at the ports that quickly, such faults are caught soon after the stimulus that exposes them.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
    localparam int unsigned DATA_W = 32;
    // word indices of the control registers, following the slot registers
    localparam int unsigned STAT_WORD = 4;
    localparam int unsigned EN_WORD   = 5;
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/hpd_debounce.sv
module hpd_debounce #(
    parameter int unsigned W      = 8,
    parameter int unsigned STABLE = 1024
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] code_in,
    output logic [W-1:0] code_acc,
    output logic         changed
);
    localparam int unsigned CW = (STABLE > 2) ? $clog2(STABLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

    typedef struct packed {
        logic [W-1:0]  cand;
        logic [CW-1:0] cnt;
        logic [W-1:0]  acc;
        logic          chg;
    } deb_t;

    deb_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        if (code_in != st_q.cand) begin
            // candidate moved: restart the stability window
            st_d.cand = code_in;
            st_d.cnt  = '0;
        end else if (st_q.cnt != LAST) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (st_q.acc != st_q.cand) begin
            st_d.acc = st_q.cand;
            st_d.chg = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_acc = st_q.acc;
    assign changed  = st_q.chg;
endmodule

// File: rtl/hotplug_detect.sv
module hotplug_detect
    import hpd_pkg::*;
#(
    parameter int unsigned NSLOT    = 4,
    parameter int unsigned CODE_W   = 8,
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned DEBOUNCE = 1024
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [NSLOT*CODE_W-1:0] slot_pins,
    output logic                    irq
);
    localparam int unsigned WIDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [NSLOT-1:0] pend;
        logic             en;
        logic             irq;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [NSLOT*CODE_W-1:0]      pins_s;
    logic [NSLOT-1:0][CODE_W-1:0] acc;
    logic [NSLOT-1:0]             chg;
    logic [WIDX_W-1:0]            widx;

    hpd_sync #(.W(NSLOT*CODE_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (slot_pins),
        .dout (pins_s)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        hpd_debounce #(.W(CODE_W), .STABLE(DEBOUNCE)) u_deb (
            .clk     (clk),
            .rst_n   (rst_n),
            .code_in (pins_s[g*CODE_W +: CODE_W]),
            .code_acc(acc[g]),
            .changed (chg[g])
        );
    end

    assign widx = bus_addr[ADDR_W-1:2];

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (widx == WIDX_W'(i)) bus_rdata = DATA_W'(acc[i]);
        end
        if (widx == WIDX_W'(STAT_WORD)) bus_rdata = DATA_W'(st_q.pend);
        if (widx == WIDX_W'(EN_WORD))   bus_rdata = DATA_W'(st_q.en);
    end

    always_comb begin
        st_d = st_q;
        if (bus_wr && widx == WIDX_W'(STAT_WORD))
            st_d.pend = st_q.pend & ~bus_wdata[NSLOT-1:0];
        if (bus_wr && widx == WIDX_W'(EN_WORD))
            st_d.en = bus_wdata[0];
        // a new change wins over a same-cycle clear
        st_d.pend = st_d.pend | chg;
        st_d.irq  = (|st_q.pend) & st_q.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/hpd_checker.sv
module hpd_checker #(
    parameter int unsigned NSLOT  = 4,
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic [NSLOT-1:0]  pend,
    input logic              en,
    input logic [NSLOT-1:0]  chg
);
    logic [ADDR_W-3:0] widx;
    logic              stat_wr;
    assign widx    = bus_addr[ADDR_W-1:2];
    assign stat_wr = bus_wr && (widx == (ADDR_W-2)'(4));

    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (widx < (ADDR_W-2)'(NSLOT)) |-> (bus_rdata[31:8] == 24'd0));

    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (widx > (ADDR_W-2)'(5)) |-> (bus_rdata == 32'd0));

    assert_change_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chg != '0) |=> ((pend & $past(chg)) == $past(chg)));

    assert_clear_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend) & ~pend) != '0) |-> $past(stat_wr));

    assert_irq_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend != '0) && en) |=> irq);

    assert_irq_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend == '0) || !en) |=> !irq);
endmodule

bind hotplug_detect hpd_checker #(.NSLOT(NSLOT), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq),
    .pend     (st_q.pend),
    .en       (st_q.en),
    .chg      (chg)
);

// File: tb/hotplug_detect_bench.sv
module hotplug_detect_bench;
    localparam int DEB = 16;
    localparam int SETTLE = DEB + 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pins = 32'h5A00_0000;   // slot 3 occupied at reset
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hotplug_detect #(.DEBOUNCE(DEB)) u_hotplug_detect (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slot_pins(pins), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic expect_rd(input logic [5:0] a, input logic [31:0] e, input string req);
        logic [31:0] d;
        rd(a, d);
        check(d == e, req, d, e);
    endtask

    task automatic t_reset;
        cyc(1);
        check(irq == 1'b0, "R2 irq in reset", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) expect_rd(6'(4*i), 32'd0, "R2 slot after reset");
        expect_rd(6'h10, 32'd0, "R2 status after reset");
        expect_rd(6'h14, 32'd0, "R2 enable after reset");
    endtask

    task automatic t_present;
        cyc(SETTLE);
        expect_rd(6'h0C, 32'h0000_005A, "R9 present slot read");
        expect_rd(6'h10, 32'h8, "R9 change set for present board");
        check(irq == 1'b0, "R7 irq masked while disabled", {31'd0, irq}, 32'd0);
        wr(6'h10, 32'h8);
        expect_rd(6'h10, 32'd0, "R5 clear present flag");
    endtask

    task automatic t_enable;
        wr(6'h14, 32'hFFFF_FFFF);
        expect_rd(6'h14, 32'd1, "R6 enable readback");
    endtask

    task automatic t_attach;
        @(negedge clk) pins[7:0] = 8'h21;
        cyc(DEB / 2);
        expect_rd(6'h00, 32'd0, "R3 not accepted before window");
        cyc(SETTLE);
        expect_rd(6'h00, 32'h21, "R1 attach code read");
        expect_rd(6'h10, 32'h1, "R4 attach flag");
        check(irq == 1'b1, "R7 irq raised", {31'd0, irq}, 32'd1);
    endtask

    task automatic t_clear;
        wr(6'h10, 32'h0);
        expect_rd(6'h10, 32'h1, "R5 write zero keeps flag");
        wr(6'h10, 32'h1);
        cyc(2);
        expect_rd(6'h10, 32'h0, "R5 write one clears");
        check(irq == 1'b0, "R7 irq drops after clear", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_detach;
        @(negedge clk) pins[7:0] = 8'h00;
        cyc(SETTLE);
        expect_rd(6'h00, 32'h0, "R4 detach reads empty");
        expect_rd(6'h10, 32'h1, "R4 detach flag");
        check(irq == 1'b1, "R7 irq on detach", {31'd0, irq}, 32'd1);
        wr(6'h14, 32'h0);
        cyc(2);
        check(irq == 1'b0, "R7 irq off when disabled", {31'd0, irq}, 32'd0);
        wr(6'h10, 32'hF);
        wr(6'h14, 32'h1);
    endtask

    task automatic t_glitch;
        @(negedge clk) pins[15:8] = 8'h44;
        cyc(4);
        pins[15:8] = 8'h00;
        cyc(SETTLE);
        expect_rd(6'h04, 32'h0, "R3 glitch ignored in slot");
        expect_rd(6'h10, 32'h0, "R3 glitch raised no flag");
    endtask

    task automatic t_swap;
        @(negedge clk) pins[23:16] = 8'h11;
        cyc(SETTLE);
        wr(6'h10, 32'h4);
        @(negedge clk) pins[23:16] = 8'h12;
        cyc(SETTLE);
        expect_rd(6'h08, 32'h12, "R4 swap code read");
        expect_rd(6'h10, 32'h4, "R4 swap flag");
        wr(6'h10, 32'h4);
    endtask

    task automatic t_write_ignore;
        wr(6'h08, 32'hFFFF_FFFF);
        expect_rd(6'h08, 32'h12, "R8 slot write ignored");
        wr(6'h04, 32'hA5A5_A5A5);
        expect_rd(6'h04, 32'h0, "R8 empty slot write ignored");
    endtask

    task automatic t_unmapped;
        expect_rd(6'h18, 32'h0, "R2 unmapped 0x18");
        expect_rd(6'h3C, 32'h0, "R2 unmapped 0x3C");
    endtask

    initial begin
        t_reset();
        t_present();
        t_enable();
        t_attach();
        t_clear();
        t_detach();
        t_glitch();
        t_swap();
        t_write_ignore();
        t_unmapped();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule